// File: doc/BRIEF.md
# Wavetable Voice Envelope Generator

This block produces the loudness envelope of a single wavetable voice. A key-on pulse starts the envelope at full volume with no attack ramp, then lets the attenuation climb through a first decay toward a programmable plateau and a second decay toward silence (-96 dB). A key-off pulse on a sounding voice switches to a release slope that runs from wherever the level stands down to silence. Reaching silence in either the second decay or release switches the voice off.

Each phase lasts a number of output samples. That number comes from an effective rate, and the effective rate is formed from a 4-bit rate value, the voice's signed octave, bit 9 of its frequency number and a rate-correction value. The level is kept as a fixed-point accumulator. At the start of each phase a serial divider works out the per-sample increment. The level moves only when the sample strobe `tick_i` is high. The output is the integer part of the accumulator in 0.375 dB steps.

Top module: `wt_env_gen`

## Requirements
- R1: After reset the voice is inactive (`active_o`=0) and `atten_o` reads 255.
- R2: A key-on pulse, whether the voice is silent or sounding, gives `atten_o`=0 and `active_o`=1 in the cycle after the pulse, and the first decay starts again from that level.
- R3: The effective rate of a 4-bit value v is 0 when v=0 and 63 when v=15. Otherwise, with correction c and the octave o taken as signed 4-bit two's complement, it is v*4 when c=15 and 2*(o+c)+F+4*v when c≠15, where F is frequency-number bit 9. The result is clamped to 0..63.
- R4: For an effective rate r, a phase lasts L samples. For 4≤r≤59, L=(15·2^(21−floor(r/4)))/(4+r mod 4) using integer division, plus 2 when (r mod 4≠0 and floor(r/4)≤11) or r=51. For r≥60, L=240.
- R5: The level is an accumulator with 23 fraction bits. Each tick adds floor(span·2^23/L), and `atten_o` is the integer part, saturated to 255 when it reaches 256. A phase ends on the first tick that brings the accumulator to or past its target.
- R6: The first decay runs from 0 toward 8·DL (increment based on span 8·DL). On reaching it, the second decay starts with span 256−8·DL. When DL=0 the first decay is skipped and the second decay starts directly from 0 with span 256.
- R7: When the second decay reaches 256, the level is set to exactly 256 (`atten_o`=255) and `active_o` drops to 0.
- R8: Key-off on an active voice starts release with span 256 minus the current accumulator, using the release rate. When release reaches 256 the voice goes inactive at attenuation 256.
- R9: Key-off on an inactive voice has no effect: `active_o` stays 0 and `atten_o` stays 255.
- R10: An effective rate below 4 gives an increment of 0, so the level does not move in that phase.
- R11: When events coincide, key-on wins over key-off and tick, and key-off wins over tick. The losing event is discarded.
- R12: Without a tick, key-on or key-off, `atten_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe per output sample |
| key_on_i | input | 1 | Key-on pulse |
| key_off_i | input | 1 | Key-off pulse |
| d1_rate_i | input | 4 | First-decay rate value |
| d2_rate_i | input | 4 | Second-decay rate value |
| rel_rate_i | input | 4 | Release rate value |
| dlev_i | input | 4 | Plateau level, target 8·value |
| rcor_i | input | 4 | Rate correction (15 disables pitch scaling) |
| oct_i | input | 4 | Octave, signed two's complement |
| fnum_msb_i | input | 1 | Frequency-number bit 9 |
| atten_o | output | ATT_W (8) | Attenuation in 0.375 dB units |
| active_o | output | 1 | Voice is sounding |

## Verification
Key events and the sample strobe can arrive in the same cycle. The dangerous cases are a key-on or key-off landing on a tick that would otherwise advance or end a phase. The bench drives key-on together with tick, key-off together with tick, and all three together. It then compares every later tick against an independent per-sample model, which shows that only the winning event took effect and that the discarded tick did not shift the envelope by one step.

// File: rtl/wt_env_pkg.sv
package wt_env_pkg;
   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_DEC1 = 2'd1,
      PH_DEC2 = 2'd2,
      PH_REL  = 2'd3
   } env_phase_e;

   localparam int RATE_W  = 6;
   localparam int RATE_MAX = 63;
endpackage

// File: rtl/wt_env_rate.sv
module wt_env_rate
   import wt_env_pkg::*;
(
   input  logic [3:0]        val_i,
   input  logic [3:0]        rcor_i,
   input  logic [3:0]        oct_i,
   input  logic              fmsb_i,
   output logic [RATE_W-1:0] rate_o
);
   logic signed [8:0] raw;

   always_comb begin
      if (rcor_i == 4'd15)
         raw = $signed({3'b000, val_i, 2'b00});
      else
         raw = ($signed({{5{oct_i[3]}}, oct_i}) + $signed({5'b00000, rcor_i})) * 9'sd2
             + $signed({8'b0, fmsb_i}) + $signed({3'b000, val_i, 2'b00});

      if (val_i == 4'd0)
         rate_o = '0;
      else if (val_i == 4'd15)
         rate_o = RATE_W'(RATE_MAX);
      else if (raw < 9'sd0)
         rate_o = '0;
      else if (raw > 9'sd63)
         rate_o = RATE_W'(RATE_MAX);
      else
         rate_o = raw[RATE_W-1:0];
   end
endmodule

// File: rtl/wt_env_len.sv
module wt_env_len
   import wt_env_pkg::*;
#(
   parameter int LEN_W = 24
) (
   input  logic [RATE_W-1:0] rate_i,
   output logic [LEN_W-1:0]  len_o
);
   localparam int BASE_W = LEN_W + 2;

   logic [4:0]        sh;
   logic [BASE_W-1:0] base;
   logic [BASE_W-1:0] quot;
   logic              adj;

   always_comb begin
      sh   = 5'd21 - 5'(rate_i[5:2]);
      base = BASE_W'(4'd15) << sh;
      quot = base / BASE_W'({1'b1, rate_i[1:0]});
      adj  = ((rate_i[1:0] != 2'd0) && (rate_i[5:2] <= 4'd11)) || (rate_i == 6'd51);
      if (rate_i < 6'd4)
         len_o = '0;
      else if (rate_i >= 6'd60)
         len_o = LEN_W'(240);
      else
         len_o = LEN_W'(quot) + (adj ? LEN_W'(2) : LEN_W'(0));
   end
endmodule

// File: rtl/wt_env_div.sv
module wt_env_div #(
   parameter int NUM_W = 32,
   parameter int DEN_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [NUM_W-1:0] quo_o
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] q_q;
   logic [DEN_W-1:0] rem_q, den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, done_q;
   logic [DEN_W:0]   trial;
   logic             take;

   assign trial = {rem_q, q_q[NUM_W-1]};
   assign take  = trial >= {1'b0, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q    <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            q_q    <= num_i;
            rem_q  <= '0;
            den_q  <= den_i;
            cnt_q  <= CNT_W'(NUM_W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            rem_q <= take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
            q_q   <= {q_q[NUM_W-2:0], take};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign quo_o  = q_q;

   // R5: the partial remainder always stays below the divisor
   p_rem_below_den_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && den_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/wt_env_gen.sv
module wt_env_gen
   import wt_env_pkg::*;
#(
   parameter int FRAC_W    = 23,
   parameter int LVL_INT_W = 9,
   parameter int LEN_W     = 24,
   parameter int ATT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             key_on_i,
   input  logic             key_off_i,
   input  logic [3:0]       d1_rate_i,
   input  logic [3:0]       d2_rate_i,
   input  logic [3:0]       rel_rate_i,
   input  logic [3:0]       dlev_i,
   input  logic [3:0]       rcor_i,
   input  logic [3:0]       oct_i,
   input  logic             fnum_msb_i,
   output logic [ATT_W-1:0] atten_o,
   output logic             active_o
);
   localparam int ACC_W = LVL_INT_W + FRAC_W;
   localparam logic [ACC_W-1:0] FULL_LVL = ACC_W'(256) << FRAC_W;
   localparam int ATT_MAX = (1 << ATT_W) - 1;

   if (LVL_INT_W < 9)  begin : g_bad_int  $error("LVL_INT_W must hold 256"); end
   if (LEN_W < 22)     begin : g_bad_len  $error("LEN_W too small for slowest phase"); end
   if (ATT_W < 8 || ATT_W > LVL_INT_W) begin : g_bad_att $error("ATT_W out of range"); end
   if (FRAC_W < 8)     begin : g_bad_frac $error("FRAC_W too small"); end

   env_phase_e        phase_q;
   logic [ACC_W-1:0]  vol_q, lim_q, step_q;
   logic              active, kon, koff, adv, hit, d1_end, div_go;
   logic [ACC_W:0]    sum;
   logic [ACC_W-1:0]  dl_tgt, num_sel;
   logic [3:0]        rate_val;
   logic [RATE_W-1:0] rate_eff;
   logic [LEN_W-1:0]  len;
   logic              div_busy, div_done;
   logic [ACC_W-1:0]  div_quo;

   assign active = (phase_q != PH_OFF);
   assign kon    = key_on_i;
   assign koff   = key_off_i && active && !key_on_i;
   assign adv    = tick_i && active && !div_busy && !div_done && !key_on_i && !koff;
   assign sum    = {1'b0, vol_q} + {1'b0, step_q};
   assign hit    = adv && (sum >= {1'b0, lim_q});
   assign d1_end = hit && (phase_q == PH_DEC1);
   assign dl_tgt = ACC_W'({dlev_i, 3'b000}) << FRAC_W;

   always_comb begin
      if (kon) begin
         rate_val = (dlev_i != 4'd0) ? d1_rate_i : d2_rate_i;
         num_sel  = (dlev_i != 4'd0) ? dl_tgt : FULL_LVL;
      end else if (koff) begin
         rate_val = rel_rate_i;
         num_sel  = FULL_LVL - vol_q;
      end else begin
         rate_val = d2_rate_i;
         num_sel  = FULL_LVL - dl_tgt;
      end
   end

   wt_env_rate u_rate (
      .val_i  (rate_val),
      .rcor_i (rcor_i),
      .oct_i  (oct_i),
      .fmsb_i (fnum_msb_i),
      .rate_o (rate_eff)
   );

   wt_env_len #(.LEN_W(LEN_W)) u_len (
      .rate_i (rate_eff),
      .len_o  (len)
   );

   assign div_go = (kon || koff || d1_end) && (len != '0);

   wt_env_div #(.NUM_W(ACC_W), .DEN_W(LEN_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_go),
      .num_i   (num_sel),
      .den_i   (len),
      .busy_o  (div_busy),
      .done_o  (div_done),
      .quo_o   (div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         vol_q   <= FULL_LVL;
         lim_q   <= FULL_LVL;
         step_q  <= '0;
      end else if (kon) begin
         vol_q   <= '0;
         step_q  <= '0;
         phase_q <= (dlev_i != 4'd0) ? PH_DEC1 : PH_DEC2;
         lim_q   <= (dlev_i != 4'd0) ? dl_tgt : FULL_LVL;
      end else if (koff) begin
         phase_q <= PH_REL;
         lim_q   <= FULL_LVL;
         step_q  <= '0;
      end else if (adv) begin
         if (hit) begin
            step_q <= '0;
            lim_q  <= FULL_LVL;
            if (phase_q == PH_DEC1) begin
               vol_q   <= sum[ACC_W-1:0];
               phase_q <= PH_DEC2;
            end else begin
               vol_q   <= FULL_LVL;
               phase_q <= PH_OFF;
            end
         end else begin
            vol_q <= sum[ACC_W-1:0];
         end
      end else if (div_done) begin
         step_q <= div_quo;
      end
   end

   if (ATT_W == LVL_INT_W) begin : g_att_full
      assign atten_o = ATT_W'(vol_q[ACC_W-1:FRAC_W]);
   end else begin : g_att_sat
      assign atten_o = (vol_q[ACC_W-1:FRAC_W] > LVL_INT_W'(ATT_MAX)) ?
                       ATT_W'(ATT_MAX) : vol_q[FRAC_W+ATT_W-1:FRAC_W];
   end

   assign active_o = active;

   // R2: key-on lands at full volume with the voice sounding
   p_keyon_full_vol_r2: assert property (@(posedge clk) disable iff (!rst_n)
      key_on_i |=> (vol_q == '0 && active_o));
   // R5: while sounding and not retriggered, attenuation never falls
   p_level_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !key_on_i) |=> (vol_q >= $past(vol_q)));
   // R7: a silent voice sits exactly at maximum attenuation
   p_off_at_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> (vol_q == FULL_LVL));
   // R9: key-off cannot wake a silent voice
   p_keyoff_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && key_off_i && !key_on_i) |=> !active_o);
   // R12: output level is frozen between events
   p_hold_no_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !key_on_i && !key_off_i) |=> $stable(atten_o));
endmodule

// File: tb/wt_env_gen_tb.sv
module wt_env_gen_tb;
   localparam int  GAP  = 38;
   localparam longint FULL = 64'd256 << 23;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, key_on_i = 1'b0, key_off_i = 1'b0;
   logic [3:0] d1_rate_i = '0, d2_rate_i = '0, rel_rate_i = '0;
   logic [3:0] dlev_i = '0, rcor_i = 4'd15, oct_i = '0;
   logic       fnum_msb_i = 1'b0;
   logic [7:0] atten_o;
   logic       active_o;

   int nvec = 0, nerr = 0;
   bit finished = 1'b0;

   longint m_vol = FULL, m_lim = FULL, m_step = 0;
   int     m_ph = 0;

   always #2.5 clk = ~clk;

   wt_env_gen u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .key_on_i(key_on_i),
      .key_off_i(key_off_i), .d1_rate_i(d1_rate_i), .d2_rate_i(d2_rate_i),
      .rel_rate_i(rel_rate_i), .dlev_i(dlev_i), .rcor_i(rcor_i), .oct_i(oct_i),
      .fnum_msb_i(fnum_msb_i), .atten_o(atten_o), .active_o(active_o)
   );

   // effective rate, R3
   function automatic int f_rate(int v);
      int o, r;
      if (v == 0) return 0;
      if (v == 15) return 63;
      o = (oct_i >= 8) ? int'(oct_i) - 16 : int'(oct_i);
      if (rcor_i != 15) r = (o + int'(rcor_i)) * 2 + int'(fnum_msb_i) + v * 4;
      else r = v * 4;
      if (r < 0) r = 0;
      if (r > 63) r = 63;
      return r;
   endfunction

   // phase length, R4 (0 for rates below 4, R10)
   function automatic longint f_len(int r);
      longint s;
      if (r < 4) return 0;
      if (r >= 60) return 240;
      s = (longint'(15) << (21 - r / 4)) / (4 + r % 4);
      if ((r % 4 != 0 && r / 4 <= 11) || r == 51) s += 2;
      return s;
   endfunction

   function automatic longint f_step(longint span, int v);
      longint l;
      l = f_len(f_rate(v));
      return (l == 0) ? 0 : span / l;
   endfunction

   function automatic int exp_att();
      longint i;
      i = m_vol >> 23;
      return (i >= 256) ? 255 : int'(i);
   endfunction

   task automatic m_keyon();
      longint tgt;
      tgt = longint'(dlev_i) * 8 << 23;
      m_vol = 0;
      if (dlev_i != 0) begin
         m_ph = 1; m_lim = tgt; m_step = f_step(tgt, int'(d1_rate_i));
      end else begin
         m_ph = 2; m_lim = FULL; m_step = f_step(FULL, int'(d2_rate_i));
      end
   endtask

   task automatic m_keyoff();
      if (m_ph != 0) begin
         m_ph = 3; m_lim = FULL; m_step = f_step(FULL - m_vol, int'(rel_rate_i));
      end
   endtask

   task automatic m_tick();
      longint s;
      if (m_ph == 0) return;
      s = m_vol + m_step;
      if (s >= m_lim) begin
         if (m_ph == 1) begin
            m_vol = s; m_ph = 2; m_lim = FULL;
            m_step = f_step(FULL - (longint'(dlev_i) * 8 << 23), int'(d2_rate_i));
         end else begin
            m_vol = FULL; m_ph = 0; m_step = 0;
         end
      end else begin
         m_vol = s;
      end
   endtask

   task automatic chk(string req, int got, int exp);
      nvec++;
      if (got != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic chk_out(string req);
      chk({req, " atten"}, int'(atten_o), exp_att());
      chk({req, " active"}, int'(active_o), (m_ph != 0) ? 1 : 0);
   endtask

   // one event cycle, model update, check, then an idle gap (R12 at its end)
   task automatic ev(bit kon, bit koff, bit tk, string req);
      @(negedge clk);
      key_on_i = kon; key_off_i = koff; tick_i = tk;
      @(negedge clk);
      key_on_i = 1'b0; key_off_i = 1'b0; tick_i = 1'b0;
      if (kon) m_keyon();
      else if (koff) m_keyoff();
      else if (tk) m_tick();
      chk_out(req);
      repeat (GAP) @(negedge clk);
      chk_out("R12 hold");
   endtask

   task automatic ticks(int n, string req);
      for (int i = 0; i < n; i++) ev(1'b0, 1'b0, 1'b1, req);
   endtask

   task automatic setup(int c1, int c2, int cr, int dl, int rc, int oc, bit fm);
      d1_rate_i = 4'(c1); d2_rate_i = 4'(c2); rel_rate_i = 4'(cr);
      dlev_i = 4'(dl); rcor_i = 4'(rc); oct_i = 4'(oc); fnum_msb_i = fm;
   endtask

   task automatic t_reset();
      chk_out("R1 reset");
   endtask

   task automatic t_full_decay();
      setup(15, 15, 15, 4, 15, 0, 1'b0);
      ev(1'b1, 1'b0, 1'b0, "R2 keyon");
      ticks(500, "R6 decay chain");
      chk("R7 shutdown active", int'(active_o), 0);
      chk("R7 shutdown atten", int'(atten_o), 255);
   endtask

   task automatic t_dl_zero();
      setup(3, 14, 15, 0, 15, 0, 1'b0);
      ev(1'b1, 1'b0, 1'b0, "R6 dl0 keyon");
      ticks(20, "R6 dl0 skip");
      chk("R6 dl0 moved", (atten_o > 0) ? 1 : 0, 1);
   endtask

   task automatic t_rates();
      setup(14, 15, 15, 15, 0, 7, 1'b1);    // clamp high
      ev(1'b1, 1'b0, 1'b0, "R3 keyon");
      ticks(25, "R3 clamp63");
      setup(14, 15, 15, 15, 2, 8, 1'b0);    // negative octave, rate 44
      ev(1'b1, 1'b0, 1'b0, "R3 keyon");
      ticks(25, "R3 negoct R4");
      setup(9, 15, 15, 15, 4, 6, 1'b1);     // bit 9 counts, rate 57
      ev(1'b1, 1'b0, 1'b0, "R3 keyon");
      ticks(25, "R3 fmsb R4");
      setup(10, 15, 15, 15, 3, 14, 1'b1);   // rate 43, +2 adjust
      ev(1'b1, 1'b0, 1'b0, "R3 keyon");
      ticks(25, "R4 adjust");
      setup(12, 15, 15, 15, 15, 8, 1'b0);   // rate 48, no adjust, RC=15
      ev(1'b1, 1'b0, 1'b0, "R3 keyon");
      ticks(25, "R4 rc15");
   endtask

   task automatic t_rate_floor();
      setup(2, 15, 15, 15, 0, 8, 1'b0);     // raw -8 -> 0
      ev(1'b1, 1'b0, 1'b0, "R10 keyon");
      ticks(10, "R10 frozen");
      chk("R10 level", int'(atten_o), 0);
      setup(0, 15, 15, 15, 15, 0, 1'b0);    // value 0 -> rate 0
      ev(1'b1, 1'b0, 1'b0, "R10 keyon");
      ticks(10, "R10 zero val");
   endtask

   task automatic t_release();
      setup(12, 15, 15, 15, 15, 0, 1'b0);
      ev(1'b1, 1'b0, 1'b0, "R8 keyon");
      ticks(60, "R8 pre");
      ev(1'b0, 1'b1, 1'b0, "R8 keyoff");
      ticks(250, "R8 release");
      chk("R8 released active", int'(active_o), 0);
   endtask

   task automatic t_idle_keyoff();
      ev(1'b0, 1'b1, 1'b0, "R9 idle keyoff");
      ev(1'b0, 1'b1, 1'b1, "R9 idle keyoff+tick");
      ticks(3, "R9 after");
      chk("R9 still off", int'(active_o), 0);
   endtask

   task automatic t_retrigger();
      setup(15, 15, 15, 10, 15, 0, 1'b0);
      ev(1'b1, 1'b0, 1'b0, "R2 keyon");
      ticks(30, "R2 run");
      ev(1'b1, 1'b0, 1'b0, "R2 retrigger");
      chk("R2 retrigger level", int'(atten_o), 0);
      ticks(10, "R2 rerun");
   endtask

   task automatic t_coincide();
      setup(15, 15, 14, 10, 15, 0, 1'b0);
      ev(1'b1, 1'b0, 1'b0, "R11 keyon");
      ticks(20, "R11 run");
      ev(1'b1, 1'b0, 1'b1, "R11 keyon+tick");
      ticks(20, "R11 after kon");
      ev(1'b0, 1'b1, 1'b1, "R11 keyoff+tick");
      ticks(20, "R11 after koff");
      ev(1'b1, 1'b1, 1'b1, "R11 all three");
      chk("R11 all three level", int'(atten_o), 0);
      ticks(20, "R11 after all");
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_full_decay();
      t_idle_keyoff();
      t_dl_zero();
      t_rates();
      t_rate_floor();
      t_release();
      t_retrigger();
      t_coincide();
      summary();
   end
endmodule